// File: doc/BRIEF.md
# Dual-Channel High-Side Switch Control Generator

This block decides, cycle by cycle, whether each of two high-side switch channels should be on or off. Each channel has its own control word, written through a simple write port. The word picks how the channel is driven. A channel can copy its direct input pin. It can be forced on or off by a static On bit. It can also run a pulse-width modulator whose timebase is either the system clock or the rising edges of an external clock.

The per-channel decision is a fixed logical mix. The direct input counts unless the direct-input-disable bit is set. That term is OR-ed with a term controlled by the register. When PWM is off, that term is the On bit alone. When PWM is on, it is the On bit AND the PWM window. The PWM has an 8-bit counter, and its window is high while the counter is below the duty value. A programmable turn-on delay, counted in PWM ticks, holds the window closed before the first PWM period begins. Slew shaping, current sensing and the analog drivers are outside this block.

Top module: `dual_switch_pwm_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every control field of both channels is zero and `sw_on` is 0. Direct-input control is therefore active from reset.
- R2: A write with `wr_en` high loads `wr_data` into the control word of channel `wr_ch` at that clock edge. The word layout is: duty in bits 7:0, PWM enable in bit 8, external-clock select in bit 9, direct-input disable in bit 10, On in bit 11, and turn-on delay in bits 15:12. Data presented while `wr_en` is low changes nothing.
- R3: While direct-input disable is 0, `sw_on[c]` is 1 one clock after `dir_in[c]` is 1, whatever the other fields hold.
- R4: While direct-input disable is 1, `dir_in[c]` has no effect on `sw_on[c]`.
- R5: With PWM enable 0, the register-controlled term equals the On bit. With direct-input disable 1, `sw_on[c]` equals On one clock later.
- R6: With PWM enable 1 and On 0, the register-controlled term is 0.
- R7: With PWM enable 1, On 1, the internal clock selected and delay 0, the output repeats every 256 clocks and is high for exactly duty clocks in each period. A duty of 0 keeps the output off.
- R8: With a turn-on delay of N, the PWM period starts N ticks after the run condition (PWM enable AND On) begins. Using the internal clock, duty 255 and N=5, `sw_on` first rises at the 6th clock edge after the write edge.
- R9: With the external clock selected, the PWM counter and the delay counter advance once per synchronised rising edge of `ext_clk`. The period is 256 external-clock periods, high for duty of them. While `ext_clk` is idle, `sw_on` does not change.
- R10: The two channels are independent. A write to one channel, and the PWM of one channel, leave the other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_in | input | NUM_CH | Direct control input per channel |
| ext_clk | input | 1 | Asynchronous external PWM timebase |
| wr_en | input | 1 | Control word write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_data | input | 16 | Control word (layout in R2) |
| sw_on | output | NUM_CH | Registered target on/off state per channel |

## Verification
The control mix is tried with all sixteen combinations of direct input, direct-input disable, On and PWM enable, using duty 0 so that the PWM term stays closed. This separates the direct path from the static path and shows that the PWM term needs On. The internal PWM is measured by counting high clocks over a whole period for several duty values: 0 shows the output stays off, 64 and 255 check the compare edge, and a delayed start locates the first rising edge exactly. The external timebase is driven at one eighth of the clock rate, so a count of eight clocks per duty step separates it from the internal rate. It is then stopped, to show that the output freezes. A split setup with one channel on PWM and the other static shows that the channels are independent.

// File: rtl/swpwm_pkg.sv
// Package: shared widths and the per-channel control word type.
// Assumes: the field order of chan_cfg_t is the write-port word layout.
package swpwm_pkg;
    localparam int DUTY_W = 8;
    localparam int DLY_W  = 4;

    typedef struct packed {
        logic [DLY_W-1:0]  dly;      // turn-on delay in PWM ticks
        logic              on;       // static On bit
        logic              dir_dis;  // direct input disable
        logic              ext_sel;  // 1: external timebase
        logic              pwm_en;   // PWM enable
        logic [DUTY_W-1:0] duty;     // duty compare value
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/swpwm_cfg_bank.sv
// Module: per-channel control word registers loaded from one write port.
// Assumes: a write with an out-of-range channel index is dropped.
module swpwm_cfg_bank
    import swpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [CFG_W-1:0] wr_data,
    output chan_cfg_t        cfg [NUM_CH]
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_cfg_t cfg_q;

        // Purpose: hold the control word, load it on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (wr_en && (wr_ch == CH_W'(c))) begin
                cfg_q <= chan_cfg_t'(wr_data);
            end
        end

        assign cfg[c] = cfg_q;
    end
endmodule

// File: rtl/swpwm_ext_sync.sv
// Module: brings the asynchronous external clock into the clk domain and
//         emits a one-cycle tick for each of its rising edges.
// Assumes: ext_clk high and low phases each last more than two clk cycles.
module swpwm_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic ext_tick
);
    logic meta_q, sync_q, prev_q;

    // Purpose: two-flop synchroniser plus one flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ext_clk;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign ext_tick = sync_q & ~prev_q;
endmodule

// File: rtl/swpwm_pwm_chan.sv
// Module: one channel's PWM timebase. It holds the turn-on delay counter and
//         the free-running duty counter, and forms the duty window.
// Assumes: the counters stay cleared while PWM enable AND On is false.
module swpwm_pwm_chan
    import swpwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      ext_tick,
    output logic      window
);
    logic              run;
    logic              tick;
    logic              holding;
    logic [DUTY_W-1:0] cnt_q;
    logic [DLY_W-1:0]  dcnt_q;

    assign run     = cfg.pwm_en & cfg.on;
    assign tick    = cfg.ext_sel ? ext_tick : 1'b1;
    assign holding = (dcnt_q < cfg.dly);

    // Purpose: count delay ticks first, then run the duty counter freely.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            dcnt_q <= '0;
        end else if (tick) begin
            if (holding) begin
                dcnt_q <= dcnt_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign window = run & ~holding & (cnt_q < cfg.duty);
endmodule

// File: rtl/dual_switch_pwm_ctrl.sv
// Module: top level. Combines, for each channel, the direct input, the On bit
//         and the PWM window into a registered switch target.
// Assumes: one external timebase pin shared by all channels.
module dual_switch_pwm_ctrl
    import swpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dir_in,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] sw_on
);
    chan_cfg_t cfg_q [NUM_CH];
    logic      ext_tick;

    swpwm_cfg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (wr_data),
        .cfg     (cfg_q)
    );

    swpwm_ext_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .ext_tick (ext_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic win;
        logic hson;

        swpwm_pwm_chan u_pwm (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg_q[c]),
            .ext_tick (ext_tick),
            .window   (win)
        );

        // Purpose: direct term OR the register-controlled term.
        always_comb begin
            hson = (dir_in[c] & ~cfg_q[c].dir_dis) |
                   (cfg_q[c].on & (cfg_q[c].pwm_en ? win : 1'b1));
        end

        // Purpose: register the channel target to give a glitch-free output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sw_on[c] <= 1'b0;
            end else begin
                sw_on[c] <= hson;
            end
        end
    end
endmodule

// File: rtl/swpwm_chk.sv
// Module: assertion checker bound to dual_switch_pwm_ctrl.
// Assumes: it sees the registered control words and the external tick.
module swpwm_chk
    import swpwm_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] dir_in,
    input logic [NUM_CH-1:0] sw_on,
    input chan_cfg_t         cfg [NUM_CH],
    input logic              ext_tick
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg[c].dir_dis && dir_in[c]) |=> sw_on[c]); // R3

        AST_STATIC_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg[c].pwm_en && cfg[c].on) |=> sw_on[c]); // R5

        AST_PWM_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[c].pwm_en && !cfg[c].on && cfg[c].dir_dis) |=> !sw_on[c]); // R6

        AST_DUTY_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[c].pwm_en && cfg[c].duty == '0 && cfg[c].dir_dis) |=> !sw_on[c]); // R7

        AST_EXT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && cfg[c].ext_sel && cfg[c].dir_dis &&
             cfg[c] == $past(cfg[c]) && !$past(ext_tick)) |=> $stable(sw_on[c])); // R9
    end
endmodule

bind dual_switch_pwm_ctrl swpwm_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_in   (dir_in),
    .sw_on    (sw_on),
    .cfg      (cfg_q),
    .ext_tick (ext_tick)
);

// File: tb/dual_switch_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module dual_switch_pwm_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dir_in = '0;
    logic        ext_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_ch = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  sw_on;
    logic        ext_run = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    dual_switch_pwm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .sw_on(sw_on)
    );

    // vector bits: {dir, dis, on, pen, expected}, duty fixed at 0
    localparam logic [4:0] VEC [16] = '{
        5'b0000_0, 5'b0001_0, 5'b0010_1, 5'b0011_0,
        5'b0100_0, 5'b0101_0, 5'b0110_1, 5'b0111_0,
        5'b1000_1, 5'b1001_1, 5'b1010_1, 5'b1011_1,
        5'b1100_0, 5'b1101_0, 5'b1110_1, 5'b1111_0
    };

    function automatic logic [15:0] word(input logic [3:0] dly, input logic on,
            input logic dis, input logic sel, input logic pen, input logic [7:0] duty);
        return {dly, on, dis, sel, pen, duty};
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic write(input logic ch, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int ch, input int cycles, output int hi);
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sw_on[ch]) hi++;
        end
    endtask

    // external timebase: toggles every 4 clocks while enabled
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int hi;
        logic ref_v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset sw_on", sw_on, 0);
        dir_in = 2'b11;
        @(posedge clk); @(negedge clk);
        check("R1 direct enabled after reset", sw_on, 3);
        dir_in = 2'b00;

        // table walk on channel 0
        for (int v = 0; v < 16; v++) begin
            dir_in[0] = VEC[v][4];
            write(1'b0, word(4'd0, VEC[v][2], VEC[v][3], 1'b0, VEC[v][1], 8'd0));
            @(posedge clk); @(negedge clk);
            check($sformatf("R3 R4 R5 R6 vector %0d", v), sw_on[0], VEC[v][0]);
        end
        dir_in = 2'b00;

        // R2: data without wr_en is ignored
        write(1'b0, word(4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0));
        @(negedge clk);
        wr_data = word(4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0); wr_ch = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 write without strobe ignored", sw_on[0], 0);

        // R7 internal PWM duty measurement
        write(1'b0, word(4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd64));
        repeat (10) @(negedge clk);
        count_high(0, 256, hi);
        check("R7 duty 64 high clocks", hi, 64);
        write(1'b0, word(4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd255));
        repeat (10) @(negedge clk);
        count_high(0, 256, hi);
        check("R7 duty 255 high clocks", hi, 255);
        write(1'b0, word(4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0));
        count_high(0, 300, hi);
        check("R7 duty 0 never high", hi, 0);

        // R8 turn-on delay of 5 ticks
        write(1'b0, word(4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0));
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 1'b0;
        wr_data = word(4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 8'd255);
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); @(negedge clk);
            check($sformatf("R8 edge %0d after write", k), sw_on[0], (k == 6) ? 1 : 0);
        end

        // R9 external timebase
        write(1'b0, word(4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0));
        ext_run = 1'b1;
        write(1'b0, word(4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd32));
        repeat (20) @(negedge clk);
        count_high(0, 2048, hi);
        check("R9 external duty 32 high clocks", hi, 256);
        write(1'b0, word(4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd128));
        repeat (1500) @(negedge clk);
        ext_run = 1'b0;
        repeat (10) @(negedge clk);
        ref_v = sw_on[0];
        hi = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sw_on[0] != ref_v) hi++;
        end
        check("R9 idle external clock output changes", hi, 0);

        // R10 independence: ch0 PWM 64, ch1 static on
        write(1'b0, word(4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd64));
        write(1'b1, word(4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0));
        repeat (10) @(negedge clk);
        count_high(0, 256, hi);
        check("R10 ch0 PWM with ch1 static", hi, 64);
        count_high(1, 256, hi);
        check("R10 ch1 static with ch0 PWM", hi, 256);

        // R1 reset mid-run clears configuration
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset clears outputs", sw_on, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 On bits cleared by reset", sw_on, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule